// File: doc/BRIEF.md
# Multi-Core Interrupt Concentrator with Periodic Timers

This block collects interrupt requests for a small group of cores and drives one request line for each output index. It handles three classes of source. Wired hardware lines are level inputs. Mailbox interrupts are raised when software writes a word into a slot. Periodic timers count clock cycles and raise a tick on expiry. Each output has its own enable mask for each class. A source reaches an output only when it is pending and its mask bit for that output is set. Which output serves which core is decided by how the cluster is wired, not by this block.

Software reaches the block through a single word-addressed read/write port. The upper address bits select a function and the low five bits select an output or a source. For each output, a read-only priority word reports three things for each class: whether an enabled source is pending, and the lowest-numbered one that is. Reading a mailbox slot returns the word written to it and retires that interrupt. Reading a timer's acknowledge register retires the tick.

Top module: `icx_concentrator`

## Requirements
- R1: The word address is {function[3:0], index[4:0]}. The function codes are:

  | Code | Function |
  |---|---|
  | 0 | mailbox |
  | 1 | timer period |
  | 2 | timer acknowledge |
  | 3 | wired-line mask set |
  | 4 | wired-line mask clear |
  | 5 | mailbox mask set |
  | 6 | mailbox mask clear |
  | 7 | timer mask set |
  | 8 | timer mask clear |
  | 9 | priority word |
  | 10 | configuration |

  Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` is sampled.
- R2: A write to mailbox slot i stores the written word and makes slot i pending. A read of slot i returns the stored word and clears the pending state.
- R3: A write of P≠0 to timer i's period register makes the timer pending P clock edges after the write edge, and again every P edges after that. A read of the acknowledge register returns the period and clears the pending state.
- R4: A timer whose period is 0 never becomes pending.
- R5: A write to a mask-set code ORs the written bits into that output's mask for that class. A write to a mask-clear code clears the written bits. A read of either code returns the mask.
- R6: In the priority word:
  - bit 0 flags a pending enabled timer, and bits 12:8 hold its index;
  - bit 1 flags a pending enabled wired line, and bits 20:16 hold its index;
  - bit 2 flags a pending enabled mailbox, and bits 28:24 hold its index;
  - all other bits read as 0.
- R7: Within a class, when several enabled sources are pending, the lowest index is reported.
- R8: `irq_out[o]` is high exactly when output o has at least one pending source whose mask bit is set, in any class.
- R9: The configuration word carries the mailbox count in bits 23:16, the wired-line count in bits 15:8 and the timer count in bits 7:0.
- R10: Reset clears every mask, every pending state and every period, and drives all `irq_out` low.
- R11: A wired line is pending only while its input is high. Nothing is latched, so `irq_out` follows the input within the same cycle.
- R12: A write whose index is beyond the implemented number of outputs or sources has no effect. A read with such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects take place at the same edge |
| bus_addr | input | 9 | Word address {function, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| hwi_in | input | NB_HWI | Wired interrupt lines, active high |
| irq_out | output | NB_OUT | One request line for each output |

## Verification
A wrong pending bit or mask bit shows up on `irq_out` in the same cycle, because the request lines are a combinational function of that state. It also shows up in the priority word, on the read that follows. A timer counter that is off by one moves its first tick by one edge. The bench therefore samples `irq_out` on the exact edge of the tick, on the edge before it, and at the next period. A mailbox or acknowledge read that fails to clear its state leaves `irq_out` high and leaves the index in the next priority word. Masked and out-of-range stimulus is checked through the same priority word and mask read-back.

// File: rtl/icx_pkg.sv
package icx_pkg;
   localparam int IDX_W  = 5;
   localparam int FUNC_W = 4;
   localparam int ADDR_W = FUNC_W + IDX_W;
   localparam int DATA_W = 32;

   typedef enum logic [FUNC_W-1:0] {
      F_MBOX    = 4'd0,
      F_PERIOD  = 4'd1,
      F_ACK     = 4'd2,
      F_HWI_SET = 4'd3,
      F_HWI_CLR = 4'd4,
      F_WTI_SET = 4'd5,
      F_WTI_CLR = 4'd6,
      F_PTI_SET = 4'd7,
      F_PTI_CLR = 4'd8,
      F_PRIO    = 4'd9,
      F_CONFIG  = 4'd10
   } icx_func_e;

   // priority word layout
   localparam int PTI_FLAG = 0;
   localparam int HWI_FLAG = 1;
   localparam int WTI_FLAG = 2;
   localparam int PTI_LSB  = 8;
   localparam int HWI_LSB  = 16;
   localparam int WTI_LSB  = 24;

   function automatic int sel_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/icx_lowest.sv
module icx_lowest #(
   parameter int W = 8
) (
   input  logic [W-1:0] vec,
   output logic         hit,
   output logic [4:0]   idx
);
   always_comb begin
      hit = |vec;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = 5'(i);
      end
   end
endmodule

// File: rtl/icx_out_sel.sv
module icx_out_sel
   import icx_pkg::*;
#(
   parameter int NB_HWI = 8,
   parameter int NB_WTI = 8,
   parameter int NB_PTI = 4
) (
   input  logic [NB_HWI-1:0] hwi_pend,
   input  logic [NB_WTI-1:0] wti_pend,
   input  logic [NB_PTI-1:0] pti_pend,
   input  logic [NB_HWI-1:0] hwi_mask,
   input  logic [NB_WTI-1:0] wti_mask,
   input  logic [NB_PTI-1:0] pti_mask,
   output logic [DATA_W-1:0] status,
   output logic              irq
);
   logic       h_hit, w_hit, p_hit;
   logic [4:0] h_idx, w_idx, p_idx;

   icx_lowest #(.W(NB_HWI)) u_h (.vec(hwi_pend & hwi_mask), .hit(h_hit), .idx(h_idx));
   icx_lowest #(.W(NB_WTI)) u_w (.vec(wti_pend & wti_mask), .hit(w_hit), .idx(w_idx));
   icx_lowest #(.W(NB_PTI)) u_p (.vec(pti_pend & pti_mask), .hit(p_hit), .idx(p_idx));

   always_comb begin
      status = '0;
      status[PTI_FLAG] = p_hit;
      status[HWI_FLAG] = h_hit;
      status[WTI_FLAG] = w_hit;
      status[PTI_LSB +: 5] = p_idx;
      status[HWI_LSB +: 5] = h_idx;
      status[WTI_LSB +: 5] = w_idx;
   end

   assign irq = h_hit | w_hit | p_hit;
endmodule

// File: rtl/icx_timer.sv
module icx_timer #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          ack,
   output logic          pend,
   output logic [CW-1:0] period
);
   logic [CW-1:0] count;
   logic          expire;

   assign expire = !load && (period != '0) && (count <= CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period <= '0;
         count  <= '0;
         pend   <= 1'b0;
      end else begin
         if (load) begin
            period <= load_val;
            count  <= load_val;
         end else if (period != '0) begin
            count <= expire ? period : count - CW'(1);
         end
         if (expire)   pend <= 1'b1;   // a new tick wins over an acknowledge
         else if (ack) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/icx_mailbox.sv
module icx_mailbox
   import icx_pkg::*;
#(
   parameter int NB_WTI = 8,
   localparam int SW    = sel_w(NB_WTI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [SW-1:0]     sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [NB_WTI-1:0] pend,
   output logic [DATA_W-1:0] rdval
);
   logic [NB_WTI-1:0][DATA_W-1:0] slot;

   for (genvar s = 0; s < NB_WTI; s++) begin : g_slot
      logic hit;
      assign hit = (sel == SW'(s));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot[s] <= '0;
            pend[s] <= 1'b0;
         end else if (wr_en && hit) begin
            slot[s] <= wdata;
            pend[s] <= 1'b1;
         end else if (rd_en && hit) begin
            pend[s] <= 1'b0;
         end
      end
   end

   assign rdval = slot[sel];
endmodule

// File: rtl/icx_concentrator.sv
module icx_concentrator
   import icx_pkg::*;
#(
   parameter int NB_OUT = 4,
   parameter int NB_HWI = 8,
   parameter int NB_WTI = 8,
   parameter int NB_PTI = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [8:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NB_HWI-1:0] hwi_in,
   output logic [NB_OUT-1:0] irq_out
);
   localparam int OW = sel_w(NB_OUT);
   localparam int WW = sel_w(NB_WTI);
   localparam int PW = sel_w(NB_PTI);

   if (NB_OUT < 1 || NB_OUT > 32) begin : g_bad_out
      $error("NB_OUT must lie in 1..32");
   end
   if (NB_HWI < 1 || NB_HWI > 32) begin : g_bad_hwi
      $error("NB_HWI must lie in 1..32");
   end
   if (NB_WTI < 1 || NB_WTI > 32) begin : g_bad_wti
      $error("NB_WTI must lie in 1..32");
   end
   if (NB_PTI < 1 || NB_PTI > 32) begin : g_bad_pti
      $error("NB_PTI must lie in 1..32");
   end

   icx_func_e  func;
   logic [4:0] idx;
   logic       out_ok, wti_ok, pti_ok;
   logic [OW-1:0] osel;
   logic [PW-1:0] psel;

   assign func   = icx_func_e'(bus_addr[ADDR_W-1:IDX_W]);
   assign idx    = bus_addr[IDX_W-1:0];
   assign out_ok = 32'(idx) < NB_OUT;
   assign wti_ok = 32'(idx) < NB_WTI;
   assign pti_ok = 32'(idx) < NB_PTI;
   assign osel   = idx[OW-1:0];
   assign psel   = idx[PW-1:0];

   // ---------------- masks ----------------
   logic [NB_OUT-1:0][NB_HWI-1:0] hwi_mask;
   logic [NB_OUT-1:0][NB_WTI-1:0] wti_mask;
   logic [NB_OUT-1:0][NB_PTI-1:0] pti_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hwi_mask <= '0;
         wti_mask <= '0;
         pti_mask <= '0;
      end else if (bus_wr && out_ok) begin
         case (func)
            F_HWI_SET: hwi_mask[osel] <= hwi_mask[osel] |  bus_wdata[NB_HWI-1:0];
            F_HWI_CLR: hwi_mask[osel] <= hwi_mask[osel] & ~bus_wdata[NB_HWI-1:0];
            F_WTI_SET: wti_mask[osel] <= wti_mask[osel] |  bus_wdata[NB_WTI-1:0];
            F_WTI_CLR: wti_mask[osel] <= wti_mask[osel] & ~bus_wdata[NB_WTI-1:0];
            F_PTI_SET: pti_mask[osel] <= pti_mask[osel] |  bus_wdata[NB_PTI-1:0];
            F_PTI_CLR: pti_mask[osel] <= pti_mask[osel] & ~bus_wdata[NB_PTI-1:0];
            default: ;
         endcase
      end
   end

   // ---------------- mailboxes ----------------
   logic [NB_WTI-1:0] wti_pend;
   logic [31:0]       mbox_rdval;

   icx_mailbox #(.NB_WTI(NB_WTI)) u_mbox (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_wr && func == F_MBOX && wti_ok),
      .rd_en (bus_rd && !bus_wr && func == F_MBOX && wti_ok),
      .sel   (idx[WW-1:0]),
      .wdata (bus_wdata),
      .pend  (wti_pend),
      .rdval (mbox_rdval)
   );

   // ---------------- timers ----------------
   logic [NB_PTI-1:0]       pti_pend;
   logic [NB_PTI-1:0][31:0] pti_period;

   for (genvar p = 0; p < NB_PTI; p++) begin : g_pti
      icx_timer #(.CW(32)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (bus_wr && func == F_PERIOD && idx == 5'(p)),
         .load_val (bus_wdata),
         .ack      (bus_rd && !bus_wr && func == F_ACK && idx == 5'(p)),
         .pend     (pti_pend[p]),
         .period   (pti_period[p])
      );
   end

   // ---------------- per-output selection ----------------
   logic [NB_OUT-1:0][31:0] status;

   for (genvar o = 0; o < NB_OUT; o++) begin : g_out
      icx_out_sel #(.NB_HWI(NB_HWI), .NB_WTI(NB_WTI), .NB_PTI(NB_PTI)) u_sel (
         .hwi_pend (hwi_in),
         .wti_pend (wti_pend),
         .pti_pend (pti_pend),
         .hwi_mask (hwi_mask[o]),
         .wti_mask (wti_mask[o]),
         .pti_mask (pti_mask[o]),
         .status   (status[o]),
         .irq      (irq_out[o])
      );
   end

   // ---------------- read path ----------------
   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (func)
         F_MBOX:              if (wti_ok) rd_mux = mbox_rdval;
         F_PERIOD, F_ACK:     if (pti_ok) rd_mux = pti_period[psel];
         F_HWI_SET, F_HWI_CLR: if (out_ok) rd_mux = 32'(hwi_mask[osel]);
         F_WTI_SET, F_WTI_CLR: if (out_ok) rd_mux = 32'(wti_mask[osel]);
         F_PTI_SET, F_PTI_CLR: if (out_ok) rd_mux = 32'(pti_mask[osel]);
         F_PRIO:              if (out_ok) rd_mux = status[osel];
         F_CONFIG:            rd_mux = {8'h00, 8'(NB_WTI), 8'(NB_HWI), 8'(NB_PTI)};
         default:             rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/icx_concentrator_chk.sv
module icx_concentrator_chk
   import icx_pkg::*;
#(
   parameter int NB_OUT = 4,
   parameter int NB_HWI = 8,
   parameter int NB_WTI = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_wr,
   input logic                          bus_rd,
   input logic [8:0]                    bus_addr,
   input logic [NB_HWI-1:0]             wdata_lo,
   input logic [2:0]                    rdata_lo,
   input logic [NB_OUT-1:0]             irq_out,
   input logic [NB_WTI-1:0]             wti_pend,
   input logic                          pti0_pend,
   input logic [31:0]                   pti0_period,
   input logic [NB_OUT-1:0][NB_HWI-1:0] hwi_mask
);
   localparam int OW = sel_w(NB_OUT);
   localparam int WW = sel_w(NB_WTI);

   logic [3:0]    fn;
   logic [4:0]    ix;
   logic [OW-1:0] osel;
   logic [WW-1:0] wsel;
   logic          irq_sel;
   logic          out_ok, wti_ok;

   assign fn      = bus_addr[8:5];
   assign ix      = bus_addr[4:0];
   assign osel    = ix[OW-1:0];
   assign wsel    = ix[WW-1:0];
   assign irq_sel = irq_out[osel];
   assign out_ok  = 32'(ix) < NB_OUT;
   assign wti_ok  = 32'(ix) < NB_WTI;

   AST_MBOX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && fn == F_MBOX && wti_ok) |=> wti_pend[$past(wsel)]); // R2

   AST_MBOX_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && fn == F_MBOX && wti_ok) |=> !wti_pend[$past(wsel)]); // R2

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && fn == F_HWI_SET && out_ok) |=>
      ((hwi_mask[$past(osel)] & $past(wdata_lo)) == $past(wdata_lo))); // R5

   AST_PRIO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && fn == F_PRIO && out_ok) |=> ((|rdata_lo) == $past(irq_sel))); // R8

   AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pti0_period == 32'd0) |=> !$rose(pti0_pend)); // R4
endmodule

bind icx_concentrator icx_concentrator_chk #(
   .NB_OUT(NB_OUT), .NB_HWI(NB_HWI), .NB_WTI(NB_WTI)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .wdata_lo    (bus_wdata[NB_HWI-1:0]),
   .rdata_lo    (bus_rdata[2:0]),
   .irq_out     (irq_out),
   .wti_pend    (wti_pend),
   .pti0_pend   (pti_pend[0]),
   .pti0_period (pti_period[0]),
   .hwi_mask    (hwi_mask)
);

// File: tb/tb_icx_concentrator.sv
module tb_icx_concentrator;
   localparam int NB_OUT = 4;
   localparam int NB_HWI = 8;
   localparam int NB_WTI = 8;
   localparam int NB_PTI = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [8:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NB_HWI-1:0] hwi_in = '0;
   logic [NB_OUT-1:0] irq_out;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   icx_concentrator #(.NB_OUT(NB_OUT), .NB_HWI(NB_HWI), .NB_WTI(NB_WTI), .NB_PTI(NB_PTI)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hwi_in(hwi_in), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // each operation uses exactly one clock edge and returns 1 ns after it
   task automatic do_wr(input logic [3:0] f, input logic [4:0] i, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = {f, i}; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [3:0] f, input logic [4:0] i, output logic [31:0] q);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = {f, i};
      @(posedge clk); #1;
      q = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
   endtask

   // {wr, func[3:0], idx[4:0], wdata[31:0], expected[31:0], req[3:0]}
   localparam int NV = 22;
   localparam logic [77:0] VEC [NV] = '{
      {1'b0, 4'd10, 5'd0,  32'h0,        32'h00080804, 4'd9},  // R9 configuration word
      {1'b0, 4'd9,  5'd0,  32'h0,        32'h00000000, 4'd10}, // R10 idle priority
      {1'b1, 4'd5,  5'd0,  32'h000000FF, 32'h0,        4'd5},
      {1'b0, 4'd5,  5'd0,  32'h0,        32'h000000FF, 4'd5},  // R5 set
      {1'b1, 4'd6,  5'd0,  32'h0000000F, 32'h0,        4'd5},
      {1'b0, 4'd5,  5'd0,  32'h0,        32'h000000F0, 4'd5},  // R5 clear
      {1'b1, 4'd0,  5'd5,  32'h12345678, 32'h0,        4'd2},
      {1'b1, 4'd0,  5'd6,  32'h0000CAFE, 32'h0,        4'd2},
      {1'b0, 4'd9,  5'd0,  32'h0,        32'h05000004, 4'd6},  // R6 R1 mailbox field
      {1'b0, 4'd0,  5'd5,  32'h0,        32'h12345678, 4'd2},  // R2 read back
      {1'b0, 4'd9,  5'd0,  32'h0,        32'h06000004, 4'd7},  // R7 next lowest
      {1'b0, 4'd0,  5'd6,  32'h0,        32'h0000CAFE, 4'd2},  // R2
      {1'b0, 4'd9,  5'd0,  32'h0,        32'h00000000, 4'd8},  // R8 all retired
      {1'b1, 4'd0,  5'd2,  32'h00000001, 32'h0,        4'd8},
      {1'b0, 4'd9,  5'd0,  32'h0,        32'h00000000, 4'd8},  // R8 masked slot
      {1'b0, 4'd0,  5'd2,  32'h0,        32'h00000001, 4'd2},  // R2
      {1'b1, 4'd0,  5'd20, 32'h00000005, 32'h0,        4'd12},
      {1'b0, 4'd0,  5'd20, 32'h0,        32'h00000000, 4'd12}, // R12 slot out of range
      {1'b0, 4'd9,  5'd0,  32'h0,        32'h00000000, 4'd12}, // R12 nothing raised
      {1'b1, 4'd5,  5'd7,  32'h000000FF, 32'h0,        4'd12},
      {1'b0, 4'd5,  5'd7,  32'h0,        32'h00000000, 4'd12}, // R12 output out of range
      {1'b0, 4'd6,  5'd0,  32'h0,        32'h000000F0, 4'd5}   // R5 clear code reads mask
   };

   initial begin
      logic [31:0] q;
      do_reset();
      chk("R10 irq after reset", 32'(irq_out), 32'h0);

      for (int k = 0; k < NV; k++) begin
         logic [77:0] e;
         e = VEC[k];
         if (e[77]) do_wr(e[76:73], e[72:68], e[67:36]);
         else begin
            do_rd(e[76:73], e[72:68], q);
            chk($sformatf("R%0d vector %0d", e[3:0], k), q, e[35:4]);
         end
      end

      // wired lines, output 1, lines 2 and 3 enabled
      do_wr(4'd3, 5'd1, 32'h0000000C);
      hwi_in = 8'h1A; #1;
      chk("R8 irq_out[1] wired", 32'(irq_out[1]), 32'h1);
      chk("R8 irq_out[0] quiet", 32'(irq_out[0]), 32'h0);
      do_rd(4'd9, 5'd1, q);
      chk("R7 wired lowest enabled", q, 32'h00030002);
      hwi_in = 8'h0C;
      do_rd(4'd9, 5'd1, q);
      chk("R7 wired two enabled", q, 32'h00020002);
      hwi_in = 8'h00; #1;
      chk("R11 line drop", 32'(irq_out[1]), 32'h0);
      do_wr(4'd4, 5'd1, 32'hFFFFFFFF);
      hwi_in = 8'hFF; #1;
      chk("R5 all masked", 32'(irq_out[1]), 32'h0);
      do_rd(4'd3, 5'd1, q);
      chk("R5 mask cleared", q, 32'h0);
      hwi_in = 8'h00;

      // two classes at once on output 0
      do_wr(4'd3, 5'd0, 32'h00000001);
      hwi_in = 8'h01;
      do_wr(4'd0, 5'd4, 32'h00000077);
      do_rd(4'd9, 5'd0, q);
      chk("R6 two classes", q, 32'h04000006);
      do_rd(4'd0, 5'd4, q);
      hwi_in = 8'h00;

      // timer 1 routed to output 2
      do_wr(4'd7, 5'd2, 32'h00000002);
      do_wr(4'd1, 5'd1, 32'd5);                 // edge E
      repeat (4) @(posedge clk); #1;            // E+4
      chk("R3 no tick before period", 32'(irq_out[2]), 32'h0);
      @(posedge clk); #1;                       // E+5
      chk("R3 tick at period", 32'(irq_out[2]), 32'h1);
      do_rd(4'd9, 5'd2, q);                     // E+6
      chk("R6 timer field", q, 32'h00000101);
      do_rd(4'd2, 5'd1, q);                     // E+7
      chk("R3 acknowledge value", q, 32'd5);
      chk("R3 acknowledge clears", 32'(irq_out[2]), 32'h0);
      repeat (2) @(posedge clk); #1;            // E+9
      chk("R3 no early repeat", 32'(irq_out[2]), 32'h0);
      @(posedge clk); #1;                       // E+10
      chk("R3 periodic repeat", 32'(irq_out[2]), 32'h1);
      do_wr(4'd1, 5'd1, 32'd0);
      do_rd(4'd2, 5'd1, q);
      repeat (20) @(posedge clk); #1;
      chk("R4 zero period idle", 32'(irq_out[2]), 32'h0);

      // reset with state present
      do_wr(4'd1, 5'd0, 32'd3);
      do_wr(4'd0, 5'd7, 32'h1);
      chk("R8 before reset", 32'(irq_out[0]), 32'h1);
      do_reset();
      chk("R10 irq cleared", 32'(irq_out), 32'h0);
      do_rd(4'd5, 5'd0, q);
      chk("R10 mask cleared", q, 32'h0);
      do_rd(4'd1, 5'd0, q);
      chk("R10 period cleared", q, 32'h0);
      do_wr(4'd5, 5'd0, 32'h80);
      do_rd(4'd9, 5'd0, q);
      chk("R10 mailbox cleared", q, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule